// File: doc/BRIEF.md
# Fragmented Receive Buffer Write Engine

The block stores the data bytes of a received message into a circular buffer of up to 256 bytes that belongs to one message object. It holds an 8-bit write offset and a byte count. Offset 0 of the buffer is kept for the byte count. Data always starts at offset 1. Every data-byte strobe becomes one write on the memory port, and the offset then advances.

At the end of each frame that is not the last frame of the message, the block compares the space left in the buffer with a threshold that depends on the protocol. If too little space is left, the buffer is treated as full. The block then writes the count to offset 0, except in plain CAN mode, rewinds to offset 1, clears the count and pulses a buffer-full output. At the end of the last frame, the block writes the count, pulses message-complete and gets ready for the next message.

Software may move the write offset at any time. The block always forces bit 0 of the new value to 1, so offset 0 never receives a data byte. Decoding of frames happens upstream and is not part of this block.

Top module: `frag_rx_dma`

## Requirements
- R1: After reset, the block makes no memory write and raises no pulse. The first data byte goes to offset 1.
- R2: A data byte presented with `byte_vld_i` is written on the next cycle at the current offset with the same value. The offset then increases by one.
- R3: When a frame ends with `frame_last_i`=1, the next cycle writes the byte count to offset 0 and pulses `msg_done_o`. The count covers the bytes since the message started or since the latest wrap. The following message starts at offset 1 with a count of 0.
- R4: With `proto_i`=2'b00 (plain CAN), a non-final frame end finds the buffer full when `buf_size_i` minus the current offset is less than 9.
- R5: With `proto_i` set to 2'b01, 2'b10 or 2'b11, a non-final frame end finds the buffer full when `buf_size_i` minus the current offset is less than 7.
- R6: On buffer-full, the byte count is written to offset 0 when `proto_i` is not 2'b00. When `proto_i` is 2'b00, no memory write takes place.
- R7: On buffer-full, `buf_full_o` pulses for one cycle. The offset returns to 1 and the count to 0, so later bytes are stored from offset 1. `buf_full_o` and `msg_done_o` are never high together.
- R8: A non-final frame end that does not find the buffer full makes no write and raises no pulse. The offset and count carry on unchanged.
- R9: A write with `ptr_wr_i` sets the offset to `ptr_wdata_i` with bit 0 forced to 1. The next data byte is stored there.
- R10: The end of a final frame never raises `buf_full_o`, however little space is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| frame_end_i | input | 1 | End-of-frame strobe |
| frame_last_i | input | 1 | Frame is the last of its message (qualified by frame_end_i) |
| proto_i | input | 2 | Protocol select; 2'b00 is plain CAN |
| buf_size_i | input | 9 | Buffer size in bytes, 1 to 256 |
| ptr_wr_i | input | 1 | Software write of the offset |
| ptr_wdata_i | input | 8 | New offset value |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 8 | Memory write offset |
| mem_wdata_o | output | 8 | Memory write data |
| buf_full_o | output | 1 | Buffer-full pulse |
| msg_done_o | output | 1 | Message-complete pulse |

## Verification
The assertions assume that the three strobes `byte_vld_i`, `frame_end_i` and `ptr_wr_i` never occur in the same cycle. They also assume that `proto_i` and `buf_size_i` stay fixed while a message is in progress. The stimulus meets both assumptions: each operation drives exactly one strobe for one cycle, and the configuration changes only between messages. The sweep covers every protocol code, a set of small buffer sizes, the full 256-byte size and frame lengths from 1 to 8. Software offset writes with even and odd values are mixed in, so the threshold boundary is reached from many starting offsets.

// File: rtl/frag_rx_pkg.sv
package frag_rx_pkg;
  localparam int unsigned OFF_W  = 8;
  localparam int unsigned SIZE_W = OFF_W + 1;

  typedef enum logic [1:0] {
    PROTO_PLAIN = 2'b00,
    PROTO_P1    = 2'b01,
    PROTO_P2    = 2'b10,
    PROTO_P3    = 2'b11
  } proto_e;

  // one cycle's worth of pointer commands
  typedef struct packed {
    logic adv;
    logic rewind;
    logic load;
  } ptr_cmd_t;
endpackage

// File: rtl/frag_full_chk.sv
module frag_full_chk
  import frag_rx_pkg::*;
#(
  parameter int unsigned OFF_W     = 8,
  parameter int unsigned PLAIN_GAP = 9,
  parameter int unsigned PROTO_GAP = 7
) (
  input  logic [1:0]     proto_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [OFF_W:0] size_i,
  output logic           full_o
);
  localparam int unsigned SUM_W = OFF_W + 2;

  logic [SUM_W-1:0] gap;
  logic [SUM_W-1:0] need;

  always_comb begin
    gap    = (proto_i == PROTO_PLAIN) ? SUM_W'(PLAIN_GAP) : SUM_W'(PROTO_GAP);
    // size - off < gap  <=>  off + gap > size, no negative intermediate
    need   = SUM_W'(off_i) + gap;
    full_o = need > SUM_W'(size_i);
  end
endmodule

// File: rtl/frag_ptr.sv
module frag_ptr
  import frag_rx_pkg::*;
#(
  parameter int unsigned OFF_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ptr_cmd_t         cmd_i,
  input  logic [OFF_W-1:0] load_val_i,
  output logic [OFF_W-1:0] off_o,
  output logic [OFF_W-1:0] cnt_o
);
  localparam logic [OFF_W-1:0] FIRST_OFF = OFF_W'(1);

  logic [OFF_W-1:0] off_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= FIRST_OFF;
      cnt_q <= '0;
    end else begin
      if (cmd_i.load)        off_q <= {load_val_i[OFF_W-1:1], 1'b1};
      else if (cmd_i.rewind) off_q <= FIRST_OFF;
      else if (cmd_i.adv)    off_q <= off_q + 1'b1;

      if (cmd_i.rewind)      cnt_q <= '0;
      else if (cmd_i.adv)    cnt_q <= cnt_q + 1'b1;
    end
  end

  assign off_o = off_q;
  assign cnt_o = cnt_q;

  assert_load_odd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.load |=> off_q[0]);

  assert_rewind_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.rewind && !cmd_i.load |=> off_q == FIRST_OFF && cnt_q == '0);

  assert_adv_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.adv && !cmd_i.rewind && !cmd_i.load |=> off_q == $past(off_q) + 1'b1);
endmodule

// File: rtl/frag_wport.sv
module frag_wport #(
  parameter int unsigned OFF_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_wr_i,
  input  logic [7:0]       data_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             cnt_wr_i,
  input  logic [OFF_W-1:0] cnt_i,
  input  logic             full_i,
  input  logic             done_i,
  output logic             we_o,
  output logic [OFF_W-1:0] addr_o,
  output logic [7:0]       wdata_o,
  output logic             full_o,
  output logic             done_o
);
  logic             we_q, full_q, done_q;
  logic [OFF_W-1:0] addr_q;
  logic [7:0]       wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      full_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      we_q   <= data_wr_i | cnt_wr_i;
      full_q <= full_i;
      done_q <= done_i;
      if (cnt_wr_i) begin
        addr_q  <= '0;
        wdata_q <= 8'(cnt_i);
      end else if (data_wr_i) begin
        addr_q  <= off_i;
        wdata_q <= data_i;
      end
    end
  end

  assign we_o    = we_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign full_o  = full_q;
  assign done_o  = done_q;

  assert_pulse_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_q && done_q));

  assert_done_writes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> we_q && addr_q == '0);
endmodule

// File: rtl/frag_rx_dma.sv
module frag_rx_dma
  import frag_rx_pkg::*;
#(
  parameter int unsigned PLAIN_GAP = 9,
  parameter int unsigned PROTO_GAP = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic             frame_end_i,
  input  logic             frame_last_i,
  input  logic [1:0]       proto_i,
  input  logic [SIZE_W-1:0] buf_size_i,
  input  logic             ptr_wr_i,
  input  logic [OFF_W-1:0] ptr_wdata_i,
  output logic             mem_we_o,
  output logic [OFF_W-1:0] mem_addr_o,
  output logic [7:0]       mem_wdata_o,
  output logic             buf_full_o,
  output logic             msg_done_o
);
  logic [OFF_W-1:0] off, cnt;
  logic             over, full_evt, done_evt, cnt_wr;
  ptr_cmd_t         cmd;

  frag_full_chk #(
    .OFF_W(OFF_W), .PLAIN_GAP(PLAIN_GAP), .PROTO_GAP(PROTO_GAP)
  ) i_full (
    .proto_i(proto_i), .off_i(off), .size_i(buf_size_i), .full_o(over)
  );

  always_comb begin
    done_evt   = frame_end_i & frame_last_i;
    full_evt   = frame_end_i & ~frame_last_i & over;
    cnt_wr     = done_evt | (full_evt & (proto_i != PROTO_PLAIN));
    cmd.adv    = byte_vld_i;
    cmd.rewind = done_evt | full_evt;
    cmd.load   = ptr_wr_i;
  end

  frag_ptr #(.OFF_W(OFF_W)) i_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd),
    .load_val_i(ptr_wdata_i), .off_o(off), .cnt_o(cnt)
  );

  frag_wport #(.OFF_W(OFF_W)) i_wport (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .data_wr_i(byte_vld_i), .data_i(byte_i), .off_i(off),
    .cnt_wr_i(cnt_wr), .cnt_i(cnt),
    .full_i(full_evt), .done_i(done_evt),
    .we_o(mem_we_o), .addr_o(mem_addr_o), .wdata_o(mem_wdata_o),
    .full_o(buf_full_o), .done_o(msg_done_o)
  );

  assert_strobes_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({byte_vld_i, frame_end_i, ptr_wr_i}));

  assert_byte_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i |=> mem_we_o && mem_wdata_o == $past(byte_i) && !buf_full_o && !msg_done_o);

  assert_last_no_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i && frame_last_i |=> msg_done_o && !buf_full_o && mem_addr_o == '0);

  assert_plain_no_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i && !frame_last_i && proto_i == PROTO_PLAIN |=> !mem_we_o);

  assert_wrap_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_full_o |-> off == OFF_W'(1));
endmodule

// File: tb/test_frag_rx_dma.sv
module test_frag_rx_dma;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_vld = 1'b0, frame_end = 1'b0, frame_last = 1'b0, ptr_wr = 1'b0;
  logic [7:0] byte_d = '0, ptr_wdata = '0;
  logic [1:0] proto = '0;
  logic [8:0] buf_size = 9'd256;
  logic       mem_we, buf_full, msg_done;
  logic [7:0] mem_addr, mem_wdata;

  int total = 0, bad = 0;
  int m_off = 1, m_cnt = 0;

  always #5 clk = ~clk;

  frag_rx_dma i_frag_rx_dma (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(byte_vld), .byte_i(byte_d),
    .frame_end_i(frame_end), .frame_last_i(frame_last), .proto_i(proto),
    .buf_size_i(buf_size), .ptr_wr_i(ptr_wr), .ptr_wdata_i(ptr_wdata),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .buf_full_o(buf_full), .msg_done_o(msg_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input bit we, input int addr, input int data,
                         input bit full, input bit done);
    chk(mem_we == we, req, "mem_we", int'(mem_we), int'(we));
    if (we) begin
      chk(int'(mem_addr) == addr, req, "mem_addr", int'(mem_addr), addr);
      chk(int'(mem_wdata) == data, req, "mem_wdata", int'(mem_wdata), data);
    end
    chk(buf_full == full, req, "buf_full", int'(buf_full), int'(full));
    chk(msg_done == done, req, "msg_done", int'(msg_done), int'(done));
  endtask

  // all tasks start and end at a falling edge
  task automatic put_byte(input logic [7:0] b);
    byte_vld = 1'b1; byte_d = b;
    @(negedge clk);
    byte_vld = 1'b0;
    chk_out("R2", 1'b1, m_off, int'(b), 1'b0, 1'b0);
    m_off = (m_off + 1) % 256;
    m_cnt = (m_cnt + 1) % 256;
  endtask

  task automatic end_frame(input bit last);
    int  gap;
    bit  full;
    gap  = (proto == 2'b00) ? 9 : 7;
    full = (int'(buf_size) - m_off) < gap;
    frame_end = 1'b1; frame_last = last;
    @(negedge clk);
    frame_end = 1'b0; frame_last = 1'b0;
    if (last) begin
      chk_out(full ? "R10" : "R3", 1'b1, 0, m_cnt, 1'b0, 1'b1);
      m_off = 1; m_cnt = 0;
    end else if (full) begin
      chk_out(proto == 2'b00 ? "R4" : "R5", proto != 2'b00, 0, m_cnt, 1'b1, 1'b0);
      chk_out("R6", proto != 2'b00, 0, m_cnt, 1'b1, 1'b0);
      m_off = 1; m_cnt = 0;
    end else begin
      chk_out("R8", 1'b0, 0, 0, 1'b0, 1'b0);
    end
  endtask

  task automatic cpu_ptr(input logic [7:0] v);
    ptr_wr = 1'b1; ptr_wdata = v;
    @(negedge clk);
    ptr_wr = 1'b0;
    chk_out("R9", 1'b0, 0, 0, 1'b0, 1'b0);
    m_off = int'(v) | 1;
  endtask

  initial begin
    #(10 * 200000);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int sizes[11] = '{12, 13, 14, 15, 16, 17, 18, 20, 23, 40, 256};
    repeat (3) @(negedge clk);
    chk_out("R1", 1'b0, 0, 0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_out("R1", 1'b0, 0, 0, 1'b0, 1'b0);
    put_byte(8'hA5);              // R1: first byte at offset 1 (m_off starts at 1)
    end_frame(1'b1);

    // R9: even value gets bit 0 forced
    cpu_ptr(8'd40);
    put_byte(8'h3C);
    cpu_ptr(8'd77);
    put_byte(8'hC3);
    end_frame(1'b1);

    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 11; s++) begin
        for (int fl = 1; fl <= 8; fl++) begin
          int nfr;
          proto = 2'(p);
          buf_size = 9'(sizes[s]);
          nfr = (3 * sizes[s]) / fl + 2;
          for (int f = 0; f < nfr; f++) begin
            if (f == 3 && fl == 3) cpu_ptr(8'((f * 37 + s * 11) & 8'hFE));
            for (int b = 0; b < fl; b++) put_byte(8'((p * 53 + f * 7 + b * 13 + s) & 8'hFF));
            end_frame(f == nfr - 1);
          end
        end
      end
    end

    // R10: final frame ending with almost no space
    proto = 2'b01; buf_size = 9'd12;
    cpu_ptr(8'd11);
    put_byte(8'h11);
    end_frame(1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule